// File: doc/BRIEF.md
# RGB to YCbCr 4:2:2 Output Converter

This block sits at the pixel output of a display controller. Each clock it accepts one 24-bit RGB pixel together with the display timing strobes: pixel valid, horizontal sync, vertical sync and data enable. It returns either the same RGB word or a 16-bit YCbCr 4:2:2 word. In the 4:2:2 form the luma travels with one chroma sample per pixel, and the chroma alternates between Cb and Cr on successive active pixels. This lets a downstream encoder or bridge use a 16-wire data bus instead of a 24-wire one.

Three bits of a 32-bit control word select the behaviour. The bits choose between conversion and pass-through, between two colorimetry matrices (SD and HD), and which chroma component leads each pixel pair. The control word is sampled only when vertical sync rises, so one frame never mixes modes. Data and timing strobes leave the block through the same three register stages, so they stay aligned.

Top module: `rgb_yc422_conv`

## Requirements
- R1: When the active enable bit (control bit 25) is set, `data_o[15:8]` carries luma, `data_o[7:0]` carries one chroma sample, and `data_o[23:16]` is zero.
- R2: With the colorimetry bit (control bit 26) set, the HD integer matrix is used: Y=(47R+157G+16B), Cb=(-26R-87G+112B), Cr=(112R-102G-10B).
- R3: With the order bit (control bit 27) clear, active pixels at even position in a line carry Cb and odd-position pixels carry Cr. The position counts only cycles with both pixel valid and data enable high.
- R4: With the order bit set, even-position pixels carry Cr and odd-position pixels carry Cb.
- R5: With the enable bit clear, `data_o` equals `rgb_i` ({R[23:16], G[15:8], B[7:0]}) from three cycles earlier, unchanged.
- R6: `pix_valid_o`, `hsync_o`, `vsync_o`, `de_o` and `data_o` all lag their inputs by exactly three clock cycles.
- R7: The chroma position returns to even at every rising edge of `de_i`, whatever length the previous line had.
- R8: With the colorimetry bit clear, the SD integer matrix is used: Y=(66R+129G+25B), Cb=(-38R-74G+112B), Cr=(112R-94G-18B). Every result is computed as (sum+128)>>8 (arithmetic) plus 16 for luma or 128 for chroma, then clipped to 0..255.
- R9: An odd-position pixel carries the second chroma component computed from the even-position pixel before it, not from its own colour.
- R10: The three control bits take effect only at the clock where `vsync_i` is high and was low the cycle before. A pixel presented in that same cycle still uses the old setting. Changes of `cfg_word` at any other time have no effect on the output.
- R11: During reset all outputs are zero, and after reset the block is in pass-through mode until the first rising edge of vertical sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_word | input | 32 | Control word; bit 25 enable, bit 26 HD colorimetry, bit 27 Cr-first |
| pix_valid_i | input | 1 | Input pixel qualifier |
| hsync_i | input | 1 | Horizontal sync in |
| vsync_i | input | 1 | Vertical sync in |
| de_i | input | 1 | Data enable in |
| rgb_i | input | 24 | Input pixel {R, G, B} |
| pix_valid_o | output | 1 | Delayed pixel qualifier |
| hsync_o | output | 1 | Delayed horizontal sync |
| vsync_o | output | 1 | Delayed vertical sync |
| de_o | output | 1 | Delayed data enable |
| data_o | output | 24 | RGB pass-through or {0, Y, C} |

## Verification
Lines of odd length, and holes in pixel valid inside data enable, check the chroma alternation. A design that counted raw cycles, or failed to restart at the line edge, would send Cr where Cb belongs on the next line. Saturated primaries, black and white check rounding and the offsets: a truncating or unsigned shift shows up as an off-by-one or a wrapped chroma value. The control word is rewritten in the middle of every frame; a design that sampled it continuously would change matrix or ordering partway through the frame. All eight control combinations are swept, so an order bit and a colorimetry bit wired to the wrong control positions fail at once.

// File: rtl/yc422_pkg.sv
package yc422_pkg;

    localparam int COEF_W = 10;
    localparam int FRAC   = 8;

    typedef struct packed {
        logic order;   // 1: Cr leads each pair
        logic sel;     // 1: HD matrix
        logic en;      // 1: convert to 4:2:2
    } cfg_t;

    typedef struct packed {
        logic pv;
        logic hs;
        logic vs;
        logic de;
    } tim_t;

    // index = row*3 + col ; row 0=Y 1=Cb 2=Cr ; col 0=R 1=G 2=B
    typedef logic [8:0][COEF_W-1:0] coef_mat_t;

    function automatic coef_mat_t coef_for(input logic hd);
        coef_mat_t m;
        if (hd) begin
            m[0] = 10'sd47;   m[1] = 10'sd157;  m[2] = 10'sd16;
            m[3] = -10'sd26;  m[4] = -10'sd87;  m[5] = 10'sd112;
            m[6] = 10'sd112;  m[7] = -10'sd102; m[8] = -10'sd10;
        end else begin
            m[0] = 10'sd66;   m[1] = 10'sd129;  m[2] = 10'sd25;
            m[3] = -10'sd38;  m[4] = -10'sd74;  m[5] = 10'sd112;
            m[6] = 10'sd112;  m[7] = -10'sd94;  m[8] = -10'sd18;
        end
        return m;
    endfunction

endpackage

// File: rtl/yc_cfg_sampler.sv
module yc_cfg_sampler
    import yc422_pkg::*;
#(
    parameter int CTRL_W  = 32,
    parameter int EN_BIT  = 25,
    parameter int SEL_BIT = 26,
    parameter int ORD_BIT = 27
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              vsync,
    output cfg_t              cfg
);

    logic vs_q;
    logic ctrl_unused;

    assign ctrl_unused = ^ctrl;

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_q <= 1'b0;
            cfg  <= '0;
        end else begin
            vs_q <= vsync;
            if (vsync && !vs_q) begin
                cfg.en    <= ctrl[EN_BIT];
                cfg.sel   <= ctrl[SEL_BIT];
                cfg.order <= ctrl[ORD_BIT];
            end
        end
    end

endmodule

// File: rtl/yc_phase_track.sv
module yc_phase_track (
    input  logic clk,
    input  logic rst,
    input  logic pv,
    input  logic de,
    output logic cur_phase
);

    logic de_q;
    logic ph_q;
    logic line_start;

    assign line_start = de && !de_q;
    assign cur_phase  = line_start ? 1'b0 : ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            de_q <= 1'b0;
            ph_q <= 1'b0;
        end else begin
            de_q <= de;
            if (line_start)
                ph_q <= pv;
            else if (pv && de)
                ph_q <= ~ph_q;
        end
    end

endmodule

// File: rtl/yc_matrix.sv
module yc_matrix
    import yc422_pkg::*;
#(
    parameter int COMP_W = 8,
    parameter int ACC_W  = COMP_W + COEF_W + 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [3*COMP_W-1:0]       rgb,
    input  cfg_t                      cfg,
    input  tim_t                      tim,
    input  logic                      phase,
    output logic signed [ACC_W-1:0]   y,
    output logic signed [ACC_W-1:0]   cb,
    output logic signed [ACC_W-1:0]   cr,
    output logic [3*COMP_W-1:0]       rgb_o,
    output cfg_t                      cfg_o,
    output tim_t                      tim_o,
    output logic                      phase_o
);

    localparam int PROD_W = COMP_W + COEF_W + 1;
    localparam logic signed [ACC_W-1:0] RND   = ACC_W'(1 << (FRAC - 1));
    localparam logic signed [ACC_W-1:0] Y_OFF = ACC_W'(16 << (COMP_W - 8));
    localparam logic signed [ACC_W-1:0] C_OFF = ACC_W'(1 << (COMP_W - 1));

    coef_mat_t                 cm;
    logic [COMP_W-1:0]         comp [3];
    logic signed [PROD_W-1:0]  prod_q [9];
    logic signed [ACC_W-1:0]   sum_w [3];
    logic signed [ACC_W-1:0]   res_q [3];

    logic [3*COMP_W-1:0]       s1_rgb;
    cfg_t                      s1_cfg;
    tim_t                      s1_tim;
    logic                      s1_phase;

    assign cm = coef_for(cfg.sel);

    generate
        for (genvar c = 0; c < 3; c++) begin : g_split
            assign comp[c] = rgb[(2-c)*COMP_W +: COMP_W];
        end

        for (genvar k = 0; k < 9; k++) begin : g_mul
            always_ff @(posedge clk) begin
                prod_q[k] <= PROD_W'($signed({1'b0, comp[k%3]})) * PROD_W'($signed(cm[k]));
            end
        end

        for (genvar r = 0; r < 3; r++) begin : g_row
            localparam logic signed [ACC_W-1:0] OFF = (r == 0) ? Y_OFF : C_OFF;
            assign sum_w[r] = ACC_W'(prod_q[3*r]) + ACC_W'(prod_q[3*r+1])
                            + ACC_W'(prod_q[3*r+2]) + RND;
            always_ff @(posedge clk) begin
                res_q[r] <= (sum_w[r] >>> FRAC) + OFF;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_rgb   <= '0;
            s1_cfg   <= '0;
            s1_tim   <= '0;
            s1_phase <= 1'b0;
            rgb_o    <= '0;
            cfg_o    <= '0;
            tim_o    <= '0;
            phase_o  <= 1'b0;
        end else begin
            s1_rgb   <= rgb;
            s1_cfg   <= cfg;
            s1_tim   <= tim;
            s1_phase <= phase;
            rgb_o    <= s1_rgb;
            cfg_o    <= s1_cfg;
            tim_o    <= s1_tim;
            phase_o  <= s1_phase;
        end
    end

    assign y  = res_q[0];
    assign cb = res_q[1];
    assign cr = res_q[2];

endmodule

// File: rtl/yc_pack.sv
module yc_pack
    import yc422_pkg::*;
#(
    parameter int COMP_W = 8,
    parameter int ACC_W  = COMP_W + COEF_W + 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [ACC_W-1:0]  y,
    input  logic signed [ACC_W-1:0]  cb,
    input  logic signed [ACC_W-1:0]  cr,
    input  logic [3*COMP_W-1:0]      rgb,
    input  cfg_t                     cfg,
    input  tim_t                     tim,
    input  logic                     phase,
    output logic [3*COMP_W-1:0]      data_o,
    output tim_t                     tim_o
);

    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << COMP_W) - 1);
    localparam logic [COMP_W-1:0]       ZERO = '0;

    function automatic logic [COMP_W-1:0] clip(input logic signed [ACC_W-1:0] v);
        if (v[ACC_W-1])
            return '0;
        else if (v > MAXV)
            return '1;
        else
            return v[COMP_W-1:0];
    endfunction

    logic [COMP_W-1:0] y_c, c_first, c_second, c_out, hold_q;
    logic              sel_unused;

    assign sel_unused = cfg.sel;
    assign y_c        = clip(y);
    assign c_first    = cfg.order ? clip(cr) : clip(cb);
    assign c_second   = cfg.order ? clip(cb) : clip(cr);
    assign c_out      = phase ? hold_q : c_first;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o <= '0;
            tim_o  <= '0;
            hold_q <= '0;
        end else begin
            tim_o <= tim;
            if (cfg.en)
                data_o <= {ZERO, y_c, c_out};
            else
                data_o <= rgb;
            if (cfg.en && tim.pv && tim.de && !phase)
                hold_q <= c_second;
        end
    end

endmodule

// File: rtl/rgb_yc422_conv.sv
module rgb_yc422_conv
    import yc422_pkg::*;
#(
    parameter int COMP_W  = 8,
    parameter int CTRL_W  = 32,
    parameter int EN_BIT  = 25,
    parameter int SEL_BIT = 26,
    parameter int ORD_BIT = 27
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CTRL_W-1:0]   cfg_word,
    input  logic                pix_valid_i,
    input  logic                hsync_i,
    input  logic                vsync_i,
    input  logic                de_i,
    input  logic [3*COMP_W-1:0] rgb_i,
    output logic                pix_valid_o,
    output logic                hsync_o,
    output logic                vsync_o,
    output logic                de_o,
    output logic [3*COMP_W-1:0] data_o
);

    localparam int ACC_W = COMP_W + COEF_W + 3;

    cfg_t                    cfg_act;
    tim_t                    tim_in, m_tim, o_tim;
    cfg_t                    m_cfg;
    logic                    phase_in, m_phase;
    logic signed [ACC_W-1:0] m_y, m_cb, m_cr;
    logic [3*COMP_W-1:0]     m_rgb;

    assign tim_in = '{pv: pix_valid_i, hs: hsync_i, vs: vsync_i, de: de_i};

    yc_cfg_sampler #(
        .CTRL_W(CTRL_W), .EN_BIT(EN_BIT), .SEL_BIT(SEL_BIT), .ORD_BIT(ORD_BIT)
    ) cfg_i (
        .clk(clk), .rst(rst), .ctrl(cfg_word), .vsync(vsync_i), .cfg(cfg_act)
    );

    yc_phase_track phase_i (
        .clk(clk), .rst(rst), .pv(pix_valid_i), .de(de_i), .cur_phase(phase_in)
    );

    yc_matrix #(.COMP_W(COMP_W), .ACC_W(ACC_W)) mtx_i (
        .clk(clk), .rst(rst), .rgb(rgb_i), .cfg(cfg_act), .tim(tim_in),
        .phase(phase_in), .y(m_y), .cb(m_cb), .cr(m_cr), .rgb_o(m_rgb),
        .cfg_o(m_cfg), .tim_o(m_tim), .phase_o(m_phase)
    );

    yc_pack #(.COMP_W(COMP_W), .ACC_W(ACC_W)) pack_i (
        .clk(clk), .rst(rst), .y(m_y), .cb(m_cb), .cr(m_cr), .rgb(m_rgb),
        .cfg(m_cfg), .tim(m_tim), .phase(m_phase), .data_o(data_o), .tim_o(o_tim)
    );

    assign pix_valid_o = o_tim.pv;
    assign hsync_o     = o_tim.hs;
    assign vsync_o     = o_tim.vs;
    assign de_o        = o_tim.de;

endmodule

// File: rtl/yc422_conv_chk.sv
module yc422_conv_chk
    import yc422_pkg::*;
#(
    parameter int COMP_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                pix_valid_i,
    input logic                hsync_i,
    input logic                vsync_i,
    input logic                de_i,
    input logic [3*COMP_W-1:0] rgb_i,
    input logic                pix_valid_o,
    input logic                hsync_o,
    input logic                vsync_o,
    input logic                de_o,
    input logic [3*COMP_W-1:0] data_o,
    input cfg_t                cfg_act
);

    localparam logic [COMP_W-1:0] Y_LO = COMP_W'(16 << (COMP_W - 8));
    localparam logic [COMP_W-1:0] Y_HI = COMP_W'(235 << (COMP_W - 8));

    logic [1:0] cnt;
    logic       vs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            vs_q <= 1'b0;
        end else begin
            vs_q <= vsync_i;
            if (cnt != 2'd3)
                cnt <= cnt + 2'd1;
        end
    end

    AST_STROBE_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (cnt == 2'd3) |-> ({pix_valid_o, hsync_o, vsync_o, de_o} ==
                           $past({pix_valid_i, hsync_i, vsync_i, de_i}, 3)));  // R6

    AST_BYPASS_EXACT: assert property (@(posedge clk) disable iff (rst)
        (cnt == 2'd3 && !$past(cfg_act.en, 3)) |-> (data_o == $past(rgb_i, 3)));  // R5

    AST_TOP_BYTE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cnt == 2'd3 && $past(cfg_act.en, 3)) |-> (data_o[3*COMP_W-1:2*COMP_W] == '0));  // R1

    AST_LUMA_RANGE: assert property (@(posedge clk) disable iff (rst)
        (cnt == 2'd3 && $past(cfg_act.en, 3)) |->
        (data_o[2*COMP_W-1:COMP_W] >= Y_LO && data_o[2*COMP_W-1:COMP_W] <= Y_HI));  // R8

    AST_CFG_AT_VSYNC: assert property (@(posedge clk) disable iff (rst)
        (cnt >= 2'd2 && cfg_act != $past(cfg_act)) |-> ($past(vsync_i) && !$past(vs_q)));  // R10

endmodule

bind rgb_yc422_conv yc422_conv_chk #(.COMP_W(COMP_W)) chk_i (
    .clk(clk), .rst(rst),
    .pix_valid_i(pix_valid_i), .hsync_i(hsync_i), .vsync_i(vsync_i), .de_i(de_i),
    .rgb_i(rgb_i),
    .pix_valid_o(pix_valid_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .data_o(data_o), .cfg_act(cfg_act)
);

// File: tb/rgb_yc422_conv_tb_top.sv
module rgb_yc422_conv_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_word = '0;
    logic        pv_i = 1'b0, hs_i = 1'b0, vs_i = 1'b0, de_i = 1'b0;
    logic [23:0] rgb_i = '0;
    logic        pv_o, hs_o, vs_o, de_o;
    logic [23:0] data_o;

    always #5 clk = ~clk;

    rgb_yc422_conv dut_i (
        .clk(clk), .rst(rst), .cfg_word(cfg_word),
        .pix_valid_i(pv_i), .hsync_i(hs_i), .vsync_i(vs_i), .de_i(de_i), .rgb_i(rgb_i),
        .pix_valid_o(pv_o), .hsync_o(hs_o), .vsync_o(vs_o), .de_o(de_o), .data_o(data_o)
    );

    int total = 0;
    int bad   = 0;

    int coef_sd [9] = '{66, 129, 25, -38, -74, 112, 112, -94, -18};
    int coef_hd [9] = '{47, 157, 16, -26, -87, 112, 112, -102, -10};

    // reference model state
    bit    m_en = 0, m_sel = 0, m_ord = 0;
    bit    m_deprev = 0, m_vsprev = 0, m_phase = 0;
    int    m_hold = 0;
    bit    mid_flag = 0;
    int    step_n = 0;
    logic [23:0] lfsr = 24'h5A3C91;

    logic [3:0]  e_tim  [4];
    logic [23:0] e_data [4];
    bit          e_yc   [4];
    string       e_ltag [4];
    string       e_ctag [4];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int mat(input bit hd, input int row, input int r, input int g, input int b);
        int v;
        if (hd) v = coef_hd[3*row]*r + coef_hd[3*row+1]*g + coef_hd[3*row+2]*b;
        else    v = coef_sd[3*row]*r + coef_sd[3*row+1]*g + coef_sd[3*row+2]*b;
        v = ((v + 128) >>> 8) + ((row == 0) ? 16 : 128);
        if (v < 0)   v = 0;
        if (v > 255) v = 255;
        return v;
    endfunction

    task automatic step(input bit pv, input bit hs, input bit vs, input bit de, input logic [23:0] rgb);
        bit first, cur;
        int y, cb, cr, cf, cs, c, slot;
        if (step_n >= 3) begin
            int o;
            o = (step_n + 1) % 4;
            chk("R6 strobes", {28'h0, pv_o, hs_o, vs_o, de_o}, {28'h0, e_tim[o]});
            if (e_tim[o][3] && e_tim[o][0]) begin
                if (!e_yc[o]) chk("R5 bypass", {8'h0, data_o}, {8'h0, e_data[o]});
                else begin
                    chk("R1 top byte", {24'h0, data_o[23:16]}, 32'h0);
                    chk(e_ltag[o], {24'h0, data_o[15:8]}, {24'h0, e_data[o][15:8]});
                    chk(e_ctag[o], {24'h0, data_o[7:0]}, {24'h0, e_data[o][7:0]});
                end
            end
        end
        pv_i = pv; hs_i = hs; vs_i = vs; de_i = de; rgb_i = rgb;
        slot  = step_n % 4;
        first = de && !m_deprev;
        cur   = first ? 1'b0 : m_phase;
        y  = mat(m_sel, 0, rgb[23:16], rgb[15:8], rgb[7:0]);
        cb = mat(m_sel, 1, rgb[23:16], rgb[15:8], rgb[7:0]);
        cr = mat(m_sel, 2, rgb[23:16], rgb[15:8], rgb[7:0]);
        cf = m_ord ? cr : cb;
        cs = m_ord ? cb : cr;
        c  = cur ? m_hold : cf;
        e_tim[slot]  = {pv, hs, vs, de};
        e_yc[slot]   = m_en;
        e_data[slot] = m_en ? {8'h0, y[7:0], c[7:0]} : rgb;
        e_ltag[slot] = m_sel ? "R2 luma hd" : "R8 luma sd";
        e_ctag[slot] = mid_flag ? "R10 chroma after late cfg write" :
                       first    ? "R7 chroma line start" :
                       cur      ? "R9 chroma second of pair" :
                       m_ord    ? "R4 chroma cr-first" : "R3 chroma cb-first";
        if (m_en && pv && de && !cur) m_hold = cs;
        if (first) m_phase = pv;
        else if (pv && de) m_phase = ~m_phase;
        m_deprev = de;
        if (vs && !m_vsprev) begin
            m_en  = cfg_word[25];
            m_sel = cfg_word[26];
            m_ord = cfg_word[27];
        end
        m_vsprev = vs;
        step_n++;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 24'h0);
    endtask

    task automatic line(input int len);
        logic [23:0] corner [6] = '{24'h000000, 24'hFFFFFF, 24'hFF0000,
                                    24'h00FF00, 24'h0000FF, 24'h808080};
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 24'h0);
        idle(3);
        for (int i = 0; i < len; i++) begin
            lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
            step((i % 7) != 5, 0, 0, 1, (i < 6) ? corner[i] : lfsr);
        end
        idle(2);
    endtask

    task automatic frame(input logic [31:0] cfg, input int len);
        cfg_word = cfg;
        idle(2);
        step(0, 0, 1, 0, 24'h0);
        step(0, 0, 1, 0, 24'h0);
        idle(3);
        line(len);
        cfg_word = ~cfg;   // must not take effect before next vsync
        mid_flag = 1;
        line(len);
        line(len + 1);
        mid_flag = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        pv_i = 1; de_i = 1; hs_i = 1; vs_i = 1; rgb_i = 24'hABCDEF;
        repeat (3) @(negedge clk);
        chk("R11 reset outputs", {3'h0, pv_o, hs_o, vs_o, de_o, data_o}, 32'h0);
        pv_i = 0; de_i = 0; hs_i = 0; vs_i = 0; rgb_i = '0;
        @(negedge clk);
        rst = 1'b0;
        // R11: before any vsync the block passes RGB even with enable requested
        cfg_word = 32'h0E00_0000;
        line(9);
        for (int f = 0; f < 8; f++) frame(32'(f) << 25, 21);
        for (int f = 7; f >= 0; f--) frame(32'(f) << 25, 16);
        idle(5);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule